// File: doc/BRIEF.md
# General-Purpose Port Register Bank with Bitwise Alias Addresses

This block is the register file of a 16-pin general-purpose port. It holds eight base registers: the pin data value, two interrupt mask vectors (A and B), and five configuration vectors. The configuration vectors are pin direction, level/edge polarity, edge-versus-level select, both-edge select and input enable. Software reaches them over a simple synchronous bus with separate read and write strobes, an access-size field, registered read data and a registered error code. Each register sits on a 4-byte stride.

The data register and both mask registers each own three extra alias addresses. Writing a 1 to a bit at the clear alias clears that bit of the base register. The set alias sets it, and the toggle alias inverts it. Reading an alias returns the base register. Software can therefore flip single pins without a read-modify-write sequence.

The block drives the pin output values and output enables. It raises a one-cycle change strobe for every output pin whose driven value a bus write has just altered. It exports all eight vectors to a separate interrupt detector. It also accepts sampled pin levels back from that detector, but only for pins that are enabled inputs.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset every register, the read data, the error code, every pin output, output enable and change strobe is 0.
- R2: The register index is the byte address divided by 4. Index 0 is data, 4 is mask A, 8 is mask B, and 12 to 16 are direction, polarity, edge select, both-edge select and input enable. A legal write to one of these base indices loads the written value, and reading it back returns that value on the exported vector and on the bus.
- R3: Index 1, 5 and 9 are the clear aliases of data, mask A and mask B. A legal write there clears every base bit where the written value is 1 and keeps the others.
- R4: Index 2, 6 and 10 are the set aliases. A legal write there ORs the written value into the base register.
- R5: Index 3, 7 and 11 are the toggle aliases. A legal write there XORs the written value into the base register.
- R6: A legal read of any index 0 to 11 returns the base register of its group of four. The value appears on bus_rdata in the cycle after the read strobe and stays there until the next read.
- R7: bus_size encodes 0 as byte, 1 as 16-bit, 2 as 32-bit and 3 as reserved, and only 1 is legal. Any other size gives error code 1 in the cycle after the access, even when the address is also unmapped. A write rejected this way changes no register, and a rejected read returns 0.
- R8: A legal-size access to a byte address with nonzero low two bits, or to an index above 16, gives error code 2 in the cycle after the access. Such a write changes no register, and such a read returns 0. Error code 0 means no error, and no access also gives code 0.
- R9: pin_oe equals the direction register. pin_out equals the data register on pins whose direction bit is 1 and is 0 elsewhere.
- R10: pin_chg is high in the cycle after a legal write to the data group or to the direction register, on exactly those pins that are outputs after the write and whose data bit changed. It is 0 after any other cycle.
- R11: The detector update replaces data bit i with det_val[i] when det_we[i] is 1, the pin's direction bit is 0 and its input-enable bit is 1, judged on the values before the edge. On such bits it takes priority over a bus write in the same cycle. On all other bits it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Byte address within the bank |
| bus_wdata | input | 16 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 16 | Registered read data |
| bus_err_code | output | 2 | Registered result: 0 ok, 1 size error, 2 unmapped |
| det_we | input | 16 | Per-pin update request from the interrupt detector |
| det_val | input | 16 | Sampled pin levels from the interrupt detector |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Pin output enables |
| pin_chg | output | 16 | One-cycle strobe per output pin whose value changed |
| data_o | output | 16 | Data register |
| mska_o | output | 16 | Interrupt mask A |
| mskb_o | output | 16 | Interrupt mask B |
| dir_o | output | 16 | Direction, 1 = output |
| polar_o | output | 16 | Polarity select |
| edge_o | output | 16 | Edge-triggered select |
| both_o | output | 16 | Both-edge select |
| inen_o | output | 16 | Input enable |

## Verification
The assertions assume that bus_wr and bus_rd are never high together. They also assume that the detector leaves det_we at zero whenever a property checks that register contents hold after a rejected or idle cycle, and those properties state that condition in their antecedents. The bench issues one access at a time, never with both strobes high. It sweeps every index up to the top of the address space with legal and illegal sizes and with aligned and misaligned addresses. It drives the detector inputs only in chosen cycles. A bench model of the eight vectors predicts every error code, every read value, every change strobe and every exported vector.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int ALIAS_GROUPS = 3;
   localparam int ALIAS_REGS   = 4 * ALIAS_GROUPS;
   localparam int CFG_REGS     = 5;
   localparam int REG_COUNT    = ALIAS_REGS + CFG_REGS;
   localparam int MIN_AW       = $clog2(REG_COUNT) + 2;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_CLEAR  = 2'd1,
      OP_SET    = 2'd2,
      OP_TOGGLE = 2'd3
   } alias_op_e;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_SIZE  = 2'd1,
      ERR_UNMAP = 2'd2
   } bank_err_e;

   localparam logic [1:0] SIZE_HALF = 2'd1;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int AW = 7,
   localparam int IW = AW - 2
)(
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   input  logic          wr,
   input  logic          rd,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic [IW-1:0] idx,
   output bank_err_e     err
);
   logic aligned;
   logic mapped;

   assign idx     = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign mapped  = aligned && (int'(idx) < REG_COUNT);

   always_comb begin
      err = ERR_NONE;
      if (wr || rd) begin
         if (size != SIZE_HALF)
            err = ERR_SIZE;
         else if (!mapped)
            err = ERR_UNMAP;
      end
   end

   assign wr_ok = wr && (err == ERR_NONE);
   assign rd_ok = rd && (err == ERR_NONE);
endmodule

// File: rtl/gpio_bank_alias_reg.sv
module gpio_bank_alias_reg
   import gpio_bank_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  alias_op_e     op,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] ovr_mask,
   input  logic [DW-1:0] ovr_val,
   output logic [DW-1:0] q,
   output logic [DW-1:0] nxt
);
   logic [DW-1:0] upd;

   always_comb begin
      unique case (op)
         OP_LOAD:   upd = wdata;
         OP_CLEAR:  upd = q & ~wdata;
         OP_SET:    upd = q | wdata;
         default:   upd = q ^ wdata;
      endcase
      nxt = we ? upd : q;
      nxt = (nxt & ~ovr_mask) | (ovr_val & ovr_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= nxt;
   end
endmodule

// File: rtl/gpio_bank_cfg_reg.sv
module gpio_bank_cfg_reg #(
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q,
   output logic [DW-1:0] nxt
);
   assign nxt = we ? wdata : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= nxt;
   end
endmodule

// File: rtl/gpio_bank_pin_drv.sv
module gpio_bank_pin_drv #(
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chg_en,
   input  logic [DW-1:0] data_q,
   input  logic [DW-1:0] dir_q,
   input  logic [DW-1:0] data_nxt,
   input  logic [DW-1:0] dir_nxt,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] pin_oe,
   output logic [DW-1:0] pin_chg
);
   logic [DW-1:0] chg_nxt;

   assign pin_oe  = dir_q;
   assign pin_out = data_q & dir_q;
   assign chg_nxt = chg_en ? (dir_nxt & (data_nxt ^ data_q)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_chg <= '0;
      else
         pin_chg <= chg_nxt;
   end
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
   import gpio_bank_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [1:0]    bus_size,
   input  logic          bus_wr,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata,
   output logic [1:0]    bus_err_code,
   input  logic [DW-1:0] det_we,
   input  logic [DW-1:0] det_val,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] pin_oe,
   output logic [DW-1:0] pin_chg,
   output logic [DW-1:0] data_o,
   output logic [DW-1:0] mska_o,
   output logic [DW-1:0] mskb_o,
   output logic [DW-1:0] dir_o,
   output logic [DW-1:0] polar_o,
   output logic [DW-1:0] edge_o,
   output logic [DW-1:0] both_o,
   output logic [DW-1:0] inen_o
);
   localparam int IW      = AW - 2;
   localparam int CFG_DIR = 0;
   localparam int CFG_EN  = 4;

   if (AW < MIN_AW) begin : g_aw_check
      $error("gpio_alias_bank: AW too small for the register map");
   end
   if (DW < 1) begin : g_dw_check
      $error("gpio_alias_bank: DW must be positive");
   end

   logic          wr_ok;
   logic          rd_ok;
   logic [IW-1:0] idx;
   bank_err_e     err;

   logic [DW-1:0] base_q   [ALIAS_GROUPS];
   logic [DW-1:0] base_nxt [ALIAS_GROUPS];
   logic [DW-1:0] cfg_q    [CFG_REGS];
   logic [DW-1:0] cfg_nxt  [CFG_REGS];
   logic [DW-1:0] det_acc;
   logic [DW-1:0] rd_val;
   logic          chg_en;
   logic [DW-1:0] rdata_q;
   bank_err_e     err_q;

   gpio_bank_decode #(.AW(AW)) i_decode (
      .addr  (bus_addr),
      .size  (bus_size),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .wr_ok (wr_ok),
      .rd_ok (rd_ok),
      .idx   (idx),
      .err   (err)
   );

   // Detector updates land only on enabled input pins, judged on current state.
   assign det_acc = det_we & ~cfg_q[CFG_DIR] & cfg_q[CFG_EN];

   for (genvar g = 0; g < ALIAS_GROUPS; g++) begin : g_alias
      logic grp_we;
      assign grp_we = wr_ok && (int'(idx) < ALIAS_REGS) && ((int'(idx) >> 2) == g);

      if (g == 0) begin : g_data
         gpio_bank_alias_reg #(.DW(DW)) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (grp_we),
            .op       (alias_op_e'(idx[1:0])),
            .wdata    (bus_wdata),
            .ovr_mask (det_acc),
            .ovr_val  (det_val),
            .q        (base_q[g]),
            .nxt      (base_nxt[g])
         );
      end else begin : g_mask
         gpio_bank_alias_reg #(.DW(DW)) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (grp_we),
            .op       (alias_op_e'(idx[1:0])),
            .wdata    (bus_wdata),
            .ovr_mask ({DW{1'b0}}),
            .ovr_val  ({DW{1'b0}}),
            .q        (base_q[g]),
            .nxt      (base_nxt[g])
         );
      end
   end

   for (genvar c = 0; c < CFG_REGS; c++) begin : g_cfg
      gpio_bank_cfg_reg #(.DW(DW)) i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_ok && (int'(idx) == ALIAS_REGS + c)),
         .wdata (bus_wdata),
         .q     (cfg_q[c]),
         .nxt   (cfg_nxt[c])
      );
   end

   // Output change check runs on data-group and direction writes only.
   assign chg_en = wr_ok && ((int'(idx) < 4) || (int'(idx) == ALIAS_REGS + CFG_DIR));

   gpio_bank_pin_drv #(.DW(DW)) i_pin_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .chg_en   (chg_en),
      .data_q   (base_q[0]),
      .dir_q    (cfg_q[CFG_DIR]),
      .data_nxt (base_nxt[0]),
      .dir_nxt  (cfg_nxt[CFG_DIR]),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .pin_chg  (pin_chg)
   );

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < ALIAS_GROUPS; g++)
         if ((int'(idx) < ALIAS_REGS) && ((int'(idx) >> 2) == g))
            rd_val = base_q[g];
      for (int c = 0; c < CFG_REGS; c++)
         if (int'(idx) == ALIAS_REGS + c)
            rd_val = cfg_q[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= ERR_NONE;
      end else begin
         err_q <= err;
         if (rd_ok)
            rdata_q <= rd_val;
         else if (bus_rd)
            rdata_q <= '0;
      end
   end

   assign bus_rdata    = rdata_q;
   assign bus_err_code = err_q;
   assign data_o       = base_q[0];
   assign mska_o       = base_q[1];
   assign mskb_o       = base_q[2];
   assign dir_o        = cfg_q[0];
   assign polar_o      = cfg_q[1];
   assign edge_o       = cfg_q[2];
   assign both_o       = cfg_q[3];
   assign inen_o       = cfg_q[4];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int AW = 7,
   parameter int DW = 16
)(
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    bus_size,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [1:0]    bus_err_code,
   input logic [DW-1:0] det_we,
   input logic [DW-1:0] pin_out,
   input logic [DW-1:0] pin_oe,
   input logic [DW-1:0] pin_chg,
   input logic [DW-1:0] data_o,
   input logic [DW-1:0] dir_o,
   input logic [DW-1:0] inen_o
);
   AST_SIZE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_size != 2'd1) |=> bus_err_code == 2'd1); // R7
   AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr || bus_rd) |=> bus_err_code == 2'd0); // R8
   AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != 2'd1 && det_we == '0) |=> ($stable(data_o) && $stable(dir_o))); // R7
   AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0); // R9
   AST_CHG_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_chg & ~pin_oe) == '0); // R10
   AST_CHG_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> pin_chg == '0); // R10
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(dir_o) && $stable(inen_o))); // R2
   AST_DET_OUT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(data_o & dir_o)); // R11
endmodule

bind gpio_alias_bank gpio_bank_chk #(.AW(AW), .DW(DW)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_size     (bus_size),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_err_code (bus_err_code),
   .det_we       (det_we),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .pin_chg      (pin_chg),
   .data_o       (data_o),
   .dir_o        (dir_o),
   .inen_o       (inen_o)
);

// File: tb/test_gpio_alias_bank.sv
module test_gpio_alias_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_size = 2'd1;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic [1:0]  bus_err_code;
   logic [15:0] det_we = '0;
   logic [15:0] det_val = '0;
   logic [15:0] pin_out, pin_oe, pin_chg;
   logic [15:0] data_o, mska_o, mskb_o, dir_o, polar_o, edge_o, both_o, inen_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl [8];      // 0 data,1 maskA,2 maskB,3 dir,4 polar,5 edge,6 both,7 inen
   logic [15:0] exp_rdata = '0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   gpio_alias_bank i_gpio_alias_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_err_code(bus_err_code), .det_we(det_we), .det_val(det_val),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_chg(pin_chg), .data_o(data_o),
      .mska_o(mska_o), .mskb_o(mskb_o), .dir_o(dir_o), .polar_o(polar_o),
      .edge_o(edge_o), .both_o(both_o), .inen_o(inen_o)
   );

   function automatic logic [31:0] nxt_rand(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk(req, "data_o", data_o, mdl[0]);
      chk(req, "mska_o", mska_o, mdl[1]);
      chk(req, "mskb_o", mskb_o, mdl[2]);
      chk(req, "dir_o", dir_o, mdl[3]);
      chk(req, "polar_o", polar_o, mdl[4]);
      chk(req, "edge_o", edge_o, mdl[5]);
      chk(req, "both_o", both_o, mdl[6]);
      chk(req, "inen_o", inen_o, mdl[7]);
      chk("R9", "pin_oe", pin_oe, mdl[3]);
      chk("R9", "pin_out", pin_out, mdl[0] & mdl[3]);
   endtask

   // One bus cycle; called at a falling edge, returns at the next one with outputs settled.
   task automatic op(input logic wr, input logic rd, input logic [6:0] a, input logic [1:0] sz,
                     input logic [15:0] wd, input logic [15:0] dwe, input logic [15:0] dval,
                     input string req);
      int          ix = int'(a[6:2]);
      logic [1:0]  e_err = 2'd0;
      logic [15:0] old_data = mdl[0];
      logic [15:0] acc = dwe & ~mdl[3] & mdl[7];
      logic [15:0] e_chg = '0;
      if (wr || rd) begin
         if (sz != 2'd1) e_err = 2'd1;
         else if (a[1:0] != 2'b00 || ix > 16) e_err = 2'd2;
      end
      if (rd) exp_rdata = (e_err != 0) ? 16'h0 : (ix < 12) ? mdl[ix >> 2] : mdl[ix - 9];
      if (wr && e_err == 0) begin
         if (ix < 12) begin
            case (ix & 3)
               0: mdl[ix >> 2] = wd;
               1: mdl[ix >> 2] = mdl[ix >> 2] & ~wd;
               2: mdl[ix >> 2] = mdl[ix >> 2] | wd;
               default: mdl[ix >> 2] = mdl[ix >> 2] ^ wd;
            endcase
         end else mdl[ix - 9] = wd;
      end
      mdl[0] = (mdl[0] & ~acc) | (dval & acc);
      if (wr && e_err == 0 && (ix < 4 || ix == 12)) e_chg = mdl[3] & (mdl[0] ^ old_data);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz; bus_wdata = wd;
      det_we = dwe; det_val = dval;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; det_we = '0; det_val = '0;
      chk((e_err == 1) ? "R7" : "R8", "err_code", {14'd0, bus_err_code}, {14'd0, e_err});
      chk("R6", "rdata", bus_rdata, exp_rdata);
      chk("R10", "pin_chg", pin_chg, e_chg);
      chk_state(req);
   endtask

   task automatic wr16(input int ix, input logic [15:0] v, input string req);
      op(1'b1, 1'b0, 7'(ix * 4), 2'd1, v, '0, '0, req);
   endtask

   task automatic rd16(input int ix, input string req);
      op(1'b0, 1'b1, 7'(ix * 4), 2'd1, '0, '0, '0, req);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_state("R1");
      chk("R1", "err_code", {14'd0, bus_err_code}, 16'd0);
      chk("R1", "rdata", bus_rdata, 16'd0);
      chk("R1", "pin_chg", pin_chg, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: every base index written and read back, R6: aliases read the base
      for (int i = 0; i < 8; i++) begin
         int bx = (i < 3) ? i * 4 : i + 9;
         wr16(bx, 16'hA5C3 ^ 16'(i * 16'h1111), "R2");
      end
      for (int ix = 0; ix < 17; ix++) rd16(ix, "R6");

      // R3, R4, R5 on each alias group
      for (int g = 0; g < 3; g++) begin
         wr16(g * 4, 16'h0F0F, "R3");
         wr16(g * 4 + 1, 16'h0300, "R3");
         wr16(g * 4 + 2, 16'hC000, "R4");
         wr16(g * 4 + 3, 16'hFFFF, "R5");
         rd16(g * 4 + 3, "R6");
      end

      // R7: wrong size, including wrong size at unmapped address
      for (int s = 0; s < 4; s++)
         if (s != 1) begin
            op(1'b1, 1'b0, 7'h00, 2'(s), 16'h1234, '0, '0, "R7");
            op(1'b1, 1'b0, 7'h50, 2'(s), 16'h1234, '0, '0, "R7");
            op(1'b0, 1'b1, 7'h30, 2'(s), '0, '0, '0, "R7");
         end

      // R8: misaligned and out-of-range
      op(1'b1, 1'b0, 7'h02, 2'd1, 16'hFFFF, '0, '0, "R8");
      op(1'b1, 1'b0, 7'h44, 2'd1, 16'hFFFF, '0, '0, "R8");
      op(1'b0, 1'b1, 7'h7C, 2'd1, '0, '0, '0, "R8");
      rd16(0, "R6");
      // R12-style hold: rdata stays after idle and writes
      op(1'b0, 1'b0, 7'h00, 2'd1, '0, '0, '0, "R6");

      // R9, R10: outputs and change strobes
      wr16(12, 16'h00FF, "R9");
      wr16(0, 16'h0000, "R10");
      wr16(3, 16'h0F0F, "R10");
      wr16(2, 16'h0F0F, "R10");
      wr16(12, 16'hFFFF, "R10");
      wr16(4, 16'hFFFF, "R10");

      // R11: detector updates on enabled inputs only
      wr16(12, 16'h00F0, "R11");
      wr16(16, 16'h0FF0, "R11");
      op(1'b0, 1'b0, 7'h00, 2'd1, '0, 16'hFFFF, 16'hAAAA, "R11");
      op(1'b0, 1'b0, 7'h00, 2'd1, '0, 16'h0F00, 16'h0000, "R11");
      op(1'b1, 1'b0, 7'h08, 2'd1, 16'hFFFF, 16'h0300, 16'h0000, "R11");

      // Near-exhaustive random sweep
      for (int n = 0; n < 4000; n++) begin
         logic [6:0]  a;
         logic [1:0]  sz;
         logic        w;
         seed = nxt_rand(seed);
         a  = (seed[3:0] == 0) ? seed[10:4] : {seed[8:4], 2'b00};
         sz = (seed[14:12] == 0) ? seed[16:15] : 2'd1;
         w  = seed[17];
         seed = nxt_rand(seed);
         op(w, !w, a, sz, seed[15:0], (seed[31:29] == 0) ? seed[31:16] : 16'h0,
            seed[23:8], "R2");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule